// File: doc/BRIEF.md
# Vectored Interrupt Priority Nesting Unit

This unit sits behind an interrupt routing stage and turns a set of up to 32 interrupt sources into a prioritised, nestable service scheme. Software assigns sources to up to sixteen ordered vector slots. Slot 0 has the highest priority. Each slot holds a handler address, and one extra default address covers sources that no enabled slot claims. The unit keeps a current service level. It gates the IRQ output so that, while a handler runs, only sources of strictly higher priority can raise IRQ again.

A handler begins by reading the vector register. That read acknowledges the most urgent pending level, records the level being left in a per-level saved-priority table, enters the new level and returns that level's handler address. The handler ends by writing any value to the same register, which returns to the saved level. The levels are the sixteen slot levels, one unvectored level (16) and an idle level (17). Side effects happen once per bus transaction, however long the strobe is held.

Top module: `vn_prio_nest`

## Requirements
- R1: After reset, every slot address, every slot control byte and the default address read back as zero, and the unit is at the idle level 17.
- R2: In a slot control byte, bit 5 enables the slot and bits 4:0 name the source it claims. A disabled slot claims no source. All 8 bits of the byte read back as written.
- R3: At the idle level, irq_o is high exactly when any bit of irq_masked_i is high.
- R4: At a slot level p (0 to 15), irq_o is high only for masked sources claimed by enabled slots numbered below p. At level 16, it is high for masked sources claimed by any enabled slot.
- R5: A read of word 12 scans levels from 0 upward, below the current level. It picks the first level i at which a raw pending source is claimed by an enabled slot numbered i or lower, or the first level i = 16 when any raw source is pending. On a hit it saves the current level for level i, enters level i and returns slot i's address. Level 16 returns the default address. The scan uses raw_pend_i as presented in the cycle of the read.
- R6: A read of word 12 that finds no such level leaves the level unchanged and returns the address of the current level. This is the default address at level 16 or at idle.
- R7: A write of any value to word 12 restores the saved level of the current level. At idle it has no effect.
- R8: A strobe held high for several cycles acts once. A held read pushes once and a held write pops once.
- R9: A write to a slot control byte changes the IRQ gating from the next cycle.
- R10: Word addresses: word 12 is the vector register, word 13 is the default address, words 0x40+k hold slot k's address and words 0x80+k hold slot k's control byte. Words 13, 0x40+k and 0x80+k read back what was written.
- R11: Nested acknowledges unwind in reverse order. After two nested reads, one write returns to the outer handler's level and a second write returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus strobe; a transaction lasts while it is high |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, valid in the same cycle |
| raw_pend_i | input | 32 | Raw pending sources, used by the acknowledge scan |
| irq_masked_i | input | 32 | Enabled IRQ sources from the routing stage |
| irq_o | output | 1 | Gated interrupt request |

## Verification
An acknowledge read can land in the same cycle that the raw pending vector gains a new, more urgent source. The scan must take the source present in that cycle, not the one from a cycle earlier. The bench drives the new raw vector and the read strobe on the same edge throughout its acknowledge sweeps. It then judges the outcome twice: from the address returned in that cycle, and from a sweep of single masked sources that shows which level the unit entered.

// File: rtl/vn_pkg.sv
package vn_pkg;
   // word addresses of the register windows
   localparam int unsigned VN_WORD_VEC       = 12;
   localparam int unsigned VN_WORD_DEF       = 13;
   localparam int unsigned VN_SLOT_ADDR_BASE = 'h40;
   localparam int unsigned VN_SLOT_CTRL_BASE = 'h80;
   // slot control byte layout
   localparam int unsigned VN_CTRL_W      = 8;
   localparam int unsigned VN_CTRL_EN_BIT = 5;
   localparam int unsigned VN_SEL_MAX_W   = 5;
endpackage

// File: rtl/vn_mask_gen.sv
// Cumulative claim masks: entry L holds sources of enabled slots below L,
// entry NUM_SLOTS all enabled slots, entry NUM_SLOTS+1 all ones (idle).
module vn_mask_gen #(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned SEL_W     = 5,
   localparam int unsigned NUM_SRC  = 1 << SEL_W,
   localparam int unsigned NUM_MASK = NUM_SLOTS + 2
) (
   input  logic [NUM_SLOTS-1:0]             en_i,
   input  logic [NUM_SLOTS-1:0][SEL_W-1:0]  sel_i,
   output logic [NUM_MASK-1:0][NUM_SRC-1:0] mask_o
);
   always_comb begin
      logic [NUM_SRC-1:0] acc;
      acc = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         mask_o[k] = acc;
         if (en_i[k]) acc[sel_i[k]] = 1'b1;
      end
      mask_o[NUM_SLOTS]   = acc;
      mask_o[NUM_SLOTS+1] = '1;
   end
endmodule

// File: rtl/vn_level_search.sv
// Finds the most urgent level below the current one with a raw source pending.
module vn_level_search #(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned SEL_W     = 5,
   localparam int unsigned NUM_SRC  = 1 << SEL_W,
   localparam int unsigned NUM_MASK = NUM_SLOTS + 2,
   localparam int unsigned PW       = $clog2(NUM_SLOTS + 2)
) (
   input  logic [NUM_SRC-1:0]                 raw_i,
   input  logic [NUM_MASK-1:1][NUM_SRC-1:0]   mask_i,
   input  logic [PW-1:0]                      cur_i,
   output logic                               hit_o,
   output logic [PW-1:0]                      lvl_o
);
   logic [NUM_SLOTS:0] hit;

   for (genvar i = 0; i <= NUM_SLOTS; i++) begin : g_lvl
      assign hit[i] = (PW'(i) < cur_i) && (|(raw_i & mask_i[i+1]));
   end

   always_comb begin
      hit_o = |hit;
      lvl_o = PW'(NUM_SLOTS + 1);
      for (int i = NUM_SLOTS; i >= 0; i--) begin
         if (hit[i]) lvl_o = PW'(i);
      end
   end
endmodule

// File: rtl/vn_nest_stack.sv
// Current level plus one saved-level entry per enterable level.
module vn_nest_stack #(
   parameter int unsigned NUM_SLOTS = 16,
   localparam int unsigned PW       = $clog2(NUM_SLOTS + 2),
   localparam int unsigned IDLE     = NUM_SLOTS + 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          push_i,
   input  logic [PW-1:0] push_lvl_i,
   input  logic          pop_i,
   output logic [PW-1:0] prio_o
);
   logic [PW-1:0] saved_q [NUM_SLOTS+1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prio_o <= PW'(IDLE);
         for (int i = 0; i <= NUM_SLOTS; i++) saved_q[i] <= PW'(IDLE);
      end else if (push_i) begin
         saved_q[push_lvl_i] <= prio_o;
         prio_o              <= push_lvl_i;
      end else if (pop_i && prio_o != PW'(IDLE)) begin
         prio_o <= saved_q[prio_o];
      end
   end
endmodule

// File: rtl/vn_prio_nest.sv
module vn_prio_nest
   import vn_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned SEL_W     = 5,
   parameter int unsigned DW        = 32,
   parameter int unsigned BUS_AW    = 8,
   localparam int unsigned NUM_SRC  = 1 << SEL_W,
   localparam int unsigned NUM_MASK = NUM_SLOTS + 2,
   localparam int unsigned PW       = $clog2(NUM_SLOTS + 2),
   localparam int unsigned IDLE     = NUM_SLOTS + 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_i,
   input  logic               we_i,
   input  logic [BUS_AW-1:0]  addr_i,
   input  logic [DW-1:0]      wdata_i,
   output logic [DW-1:0]      rdata_o,
   input  logic [NUM_SRC-1:0] raw_pend_i,
   input  logic [NUM_SRC-1:0] irq_masked_i,
   output logic               irq_o
);
   // elaboration-time parameter checks
   if (NUM_SLOTS < 1 || NUM_SLOTS > 16) begin : g_bad_slots
      $error("NUM_SLOTS must be 1..16");
   end
   if (SEL_W < 1 || SEL_W > VN_SEL_MAX_W) begin : g_bad_sel
      $error("SEL_W must be 1..5");
   end
   if (DW < VN_CTRL_W) begin : g_bad_dw
      $error("DW must hold a control byte");
   end
   if (BUS_AW < 8) begin : g_bad_aw
      $error("BUS_AW must reach the control window");
   end

   // one action per transaction: first cycle of the strobe only
   logic req_q, first, ack_pulse, eoi_pulse, wr_pulse;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= req_i;
   end
   assign first     = req_i & ~req_q;
   assign wr_pulse  = first & we_i;
   assign ack_pulse = first & ~we_i & (addr_i == BUS_AW'(VN_WORD_VEC));
   assign eoi_pulse = wr_pulse & (addr_i == BUS_AW'(VN_WORD_VEC));

   // programmable storage
   logic [DW-1:0]        saddr_q [NUM_SLOTS];
   logic [VN_CTRL_W-1:0] sctl_q  [NUM_SLOTS];
   logic [DW-1:0]        def_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         def_q <= '0;
         for (int k = 0; k < NUM_SLOTS; k++) begin
            saddr_q[k] <= '0;
            sctl_q[k]  <= '0;
         end
      end else if (wr_pulse) begin
         if (addr_i == BUS_AW'(VN_WORD_DEF)) def_q <= wdata_i;
         for (int k = 0; k < NUM_SLOTS; k++) begin
            if (addr_i == BUS_AW'(VN_SLOT_ADDR_BASE + k)) saddr_q[k] <= wdata_i;
            if (addr_i == BUS_AW'(VN_SLOT_CTRL_BASE + k)) sctl_q[k]  <= wdata_i[VN_CTRL_W-1:0];
         end
      end
   end

   logic [NUM_SLOTS-1:0]            slot_en;
   logic [NUM_SLOTS-1:0][SEL_W-1:0] slot_sel;
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_field
      assign slot_en[k]  = sctl_q[k][VN_CTRL_EN_BIT];
      assign slot_sel[k] = sctl_q[k][SEL_W-1:0];
   end

   logic [NUM_MASK-1:0][NUM_SRC-1:0] masks;
   vn_mask_gen #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_masks (
      .en_i   (slot_en),
      .sel_i  (slot_sel),
      .mask_o (masks)
   );

   logic [PW-1:0] prio, hit_lvl;
   logic          hit;
   vn_level_search #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_search (
      .raw_i  (raw_pend_i),
      .mask_i (masks[NUM_MASK-1:1]),
      .cur_i  (prio),
      .hit_o  (hit),
      .lvl_o  (hit_lvl)
   );

   vn_nest_stack #(.NUM_SLOTS(NUM_SLOTS)) u_stack (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (ack_pulse & hit),
      .push_lvl_i (hit_lvl),
      .pop_i      (eoi_pulse),
      .prio_o     (prio)
   );

   assign irq_o = |(irq_masked_i & masks[prio]);

   // address returned by an acknowledge read
   logic [PW-1:0] vec_lvl;
   logic [DW-1:0] vec_val;
   always_comb begin
      vec_lvl = hit ? hit_lvl : prio;
      vec_val = def_q;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (vec_lvl == PW'(k)) vec_val = saddr_q[k];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == BUS_AW'(VN_WORD_VEC)) rdata_o = vec_val;
      if (addr_i == BUS_AW'(VN_WORD_DEF)) rdata_o = def_q;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (addr_i == BUS_AW'(VN_SLOT_ADDR_BASE + k)) rdata_o = saddr_q[k];
         if (addr_i == BUS_AW'(VN_SLOT_CTRL_BASE + k)) rdata_o = DW'(sctl_q[k]);
      end
   end
endmodule

// File: rtl/vn_prio_nest_chk.sv
module vn_prio_nest_chk #(
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned NUM_SRC   = 32,
   parameter int unsigned PW        = 5
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_i,
   input logic               req_q,
   input logic               ack_pulse,
   input logic               eoi_pulse,
   input logic [PW-1:0]      prio,
   input logic               irq_o,
   input logic [NUM_SRC-1:0] irq_masked_i
);
   localparam logic [PW-1:0] IDLE = PW'(NUM_SLOTS + 1);

   a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(rst_ni) |-> prio == IDLE);

   a_r3_idle_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prio == IDLE |-> irq_o == (|irq_masked_i));

   a_r4_top_level_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prio == '0 |-> !irq_o);

   a_r5_ack_never_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_pulse |=> prio <= $past(prio));

   a_r7_idle_eoi_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_pulse && prio == IDLE) |=> prio == IDLE);

   a_r11_pop_returns_outward: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_pulse && prio != IDLE) |=> prio > $past(prio));

   a_r8_held_strobe_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && req_q) |=> $stable(prio));
endmodule

bind vn_prio_nest vn_prio_nest_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .NUM_SRC   (NUM_SRC),
   .PW        (PW)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_i        (req_i),
   .req_q        (req_q),
   .ack_pulse    (ack_pulse),
   .eoi_pulse    (eoi_pulse),
   .prio         (prio),
   .irq_o        (irq_o),
   .irq_masked_i (irq_masked_i)
);

// File: tb/vn_prio_nest_tb.sv
module vn_prio_nest_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic [31:0] raw = '0, masked = '0;
   logic        irq;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   vn_prio_nest dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .raw_pend_i(raw),
      .irq_masked_i(masked), .irq_o(irq)
   );

   // requirement-level model state
   logic [7:0]  m_ctl [16];
   logic [31:0] m_adr [16];
   logic [31:0] m_def;
   int          m_prio;
   int          m_saved [17];

   function automatic int src_of(input int k);
      return (7 * k + 1) % 32;
   endfunction

   function automatic logic [31:0] m_mask(input int lvl);
      logic [31:0] acc;
      acc = '0;
      if (lvl >= 17) return '1;
      for (int j = 0; j < lvl && j < 16; j++)
         if (m_ctl[j][5]) acc[m_ctl[j][4:0]] = 1'b1;
      return acc;
   endfunction

   function automatic logic [31:0] m_vec(input int lvl);
      return (lvl < 16) ? m_adr[lvl] : m_def;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk); req = 1'b0; we = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
      #1 chk(tag, rdata, exp);
      @(negedge clk); req = 1'b0;
   endtask

   // R5/R6: raw vector and read strobe change on the same edge
   task automatic do_ack(input logic [31:0] r, input string tag, input int hold = 1);
      int found;
      logic [31:0] e;
      found = -1;
      for (int i = 0; i < m_prio; i++)
         if ((r & m_mask(i + 1)) != 0) begin found = i; break; end
      e = (found >= 0) ? m_vec(found) : m_vec(m_prio);
      @(negedge clk); raw = r; req = 1'b1; we = 1'b0; addr = 8'd12;
      #1 chk(tag, rdata, e);
      for (int h = 1; h < hold; h++) begin
         @(negedge clk);
         #1 chk({tag, " held R8"}, rdata, e);
      end
      @(negedge clk); req = 1'b0;
      if (found >= 0) begin
         m_saved[found] = m_prio;
         m_prio = found;
      end
   endtask

   task automatic do_eoi(input int hold = 1);
      @(negedge clk); req = 1'b1; we = 1'b1; addr = 8'd12; wdata = 32'hA5A5_5A5A;
      repeat (hold) @(negedge clk);
      req = 1'b0; we = 1'b0;
      if (m_prio < 17) m_prio = m_saved[m_prio];
   endtask

   // single-source sweep of the gated output at the current level
   task automatic sweep_irq(input string tag);
      for (int b = 0; b < 32; b++) begin
         @(negedge clk); masked = 32'h1 << b;
         #1 chk(tag, {31'b0, irq}, {31'b0, |(m_mask(m_prio) & masked)});
      end
      @(negedge clk); masked = '0;
      #1 chk({tag, " none"}, {31'b0, irq}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_def = '0; m_prio = 17;
      for (int k = 0; k < 16; k++) begin m_ctl[k] = '0; m_adr[k] = '0; end
      for (int k = 0; k < 17; k++) m_saved[k] = 17;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1 chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      for (int k = 0; k < 16; k++) begin
         rd_chk(8'h40 + 8'(k), 32'h0, "R1 slot addr reset");
         rd_chk(8'h80 + 8'(k), 32'h0, "R1 slot ctrl reset");
      end
      rd_chk(8'd13, 32'h0, "R1 default reset");
      do_ack(32'h0, "R1 R6 idle empty ack");
      sweep_irq("R1 R3 idle after reset");

      // R10/R2: program and read back; slot 9 disabled with upper bits set
      for (int k = 0; k < 16; k++) begin
         m_adr[k] = 32'h1000 + 32'(k) * 32'h40;
         m_ctl[k] = (k == 9) ? (8'hC0 | 8'(src_of(k))) : (8'h20 | 8'(src_of(k)));
         wr_reg(8'h40 + 8'(k), m_adr[k]);
         wr_reg(8'h80 + 8'(k), {24'hFFFFFF, m_ctl[k]});
      end
      m_def = 32'hD0F0_0000;
      wr_reg(8'd13, m_def);
      for (int k = 0; k < 16; k++) begin
         rd_chk(8'h40 + 8'(k), m_adr[k], "R10 slot addr readback");
         rd_chk(8'h80 + 8'(k), {24'h0, m_ctl[k]}, "R2 R10 slot ctrl readback");
      end
      rd_chk(8'd13, m_def, "R10 default readback");
      rd_chk(8'd50, 32'h0, "R10 unmapped word reads zero");
      sweep_irq("R3 idle gate programmed");

      // R4/R5/R7: acknowledge each slot with a lower-priority source also pending
      for (int k = 0; k < 16; k++) begin
         do_ack((32'h1 << src_of(k)) | (32'h1 << src_of(15)) | 32'h4, "R5 ack slot sweep");
         sweep_irq("R4 gate at level");
         do_eoi();
         sweep_irq("R7 back after eoi");
      end

      // R6/R2: unvectored and disabled-slot sources go to level 16
      do_ack(32'h4, "R6 unvectored ack");
      sweep_irq("R4 gate at level 16");
      do_ack(32'h0, "R6 no pending at 16");
      do_ack(32'h1 << src_of(9), "R2 disabled slot at 16");
      do_eoi();
      do_ack(32'h1 << src_of(9), "R2 R6 disabled slot from idle");
      sweep_irq("R2 disabled slot excluded");
      do_eoi();
      do_eoi();
      sweep_irq("R7 idle eoi no effect");

      // R11: nesting unwinds in order
      do_ack(32'h1 << src_of(8), "R11 outer ack");
      do_ack((32'h1 << src_of(8)) | (32'h1 << src_of(3)), "R11 inner ack");
      sweep_irq("R11 inner level gate");
      do_eoi();
      sweep_irq("R11 back at outer");
      do_eoi();
      sweep_irq("R11 back at idle");

      // R8: held strobes act once
      do_ack(32'h1 << src_of(8), "R8 outer ack");
      do_ack((32'h1 << src_of(3)) | (32'h1 << src_of(8)), "R8 inner ack");
      do_eoi(4);
      sweep_irq("R8 held eoi pops once");
      do_eoi();
      do_ack(32'h1 << src_of(5), "R8 held ack", 4);
      sweep_irq("R8 held ack level");
      do_eoi();
      sweep_irq("R8 idle after single eoi");

      // R9: reprogramming a slot control while in service
      do_ack(32'h1 << src_of(10), "R9 enter level 10");
      @(negedge clk); masked = 32'h1 << src_of(5);
      #1 chk("R9 slot 5 gates before change", {31'b0, irq}, 32'h1);
      m_ctl[5] = 8'(src_of(5));
      wr_reg(8'h85, {24'h0, m_ctl[5]});
      masked = 32'h1 << src_of(5);
      #1 chk("R9 slot 5 disabled next cycle", {31'b0, irq}, 32'h0);
      m_ctl[5] = 8'h20 | 8'(src_of(5));
      wr_reg(8'h85, {24'h0, m_ctl[5]});
      #1 chk("R9 slot 5 enabled next cycle", {31'b0, irq}, 32'h1);
      sweep_irq("R9 gate after reprogram");
      do_eoi();
      sweep_irq("R9 idle");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule